// File: doc/BRIEF.md
# Disk DMA Channel Control Unit

This unit is the control and status front end of one channel of a packet-driven disk DMA engine. Software reaches it over a small 16-bit register bus. Through that bus it sets the PIO timing mode, the packet count, the next-packet pointer and the two FIFO thresholds. It also starts and resets the engine and reads back the channel's event flags. Descriptor fetch and data movement belong to the engine behind the unit. The unit only hands the engine its configuration, a one-cycle start pulse and a reset level, and it collects the engine's completion and error events.

A small channel state machine tracks the engine and has three states. IDLE is the rest state. RUN means a start was accepted. HALT means the reset bit in the control word is set. It has four transitions:
- GO: IDLE to RUN, on an accepted start.
- FINISH: RUN to IDLE, on the engine's done event.
- HOLD: IDLE or RUN to HALT, while the reset bit is set.
- RELEASE: HALT to IDLE, once the reset bit is cleared.

A start is honoured only when all three conditions hold: a key register has been loaded with the unlock value, the channel is IDLE, and no reset is pending. Status flags are sticky and are cleared by the act of reading them. The interrupt line is the OR of the flags unless the control word masks it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the control word reads 0x0100 (interrupt masked, mode 0), status reads 0x0000, the key register reads 0, and irq, eng_start and eng_reset are low.
- R2: Packet count (0x04), next pointer low/high halves (0x0C/0x0E), input threshold (0x14) and output threshold (0x16) store written 16-bit values, read them back, and drive the matching outputs. Control bits 1:0 drive pio_mode.
- R3: The start gate opens only while the key register at 0x1E holds 7. Writing any other value closes the gate again.
- R4: Writing control (0x00) with bit 7 set, when the gate is open, the channel is IDLE and the reset bit is clear in both the written word and the stored control word, gives eng_start high for exactly the one cycle after the write. Bit 7 always reads back 0.
- R5: A start request made while the gate is closed, while in RUN, while in HALT, or together with bit 5 gives no eng_start pulse.
- R6: Control bit 5 set moves the channel to HALT and holds eng_reset high. Clearing it returns the channel to IDLE, where a start is accepted again.
- R7: eng_done in RUN returns the channel to IDLE and sets status bit 2. eng_done outside RUN leaves status unchanged.
- R8: evt_seq, evt_unexp and evt_buserr set status bits 6, 4 and 0 respectively, and the bits stay set until read.
- R9: A read of status (0x02) returns the flags in bus_rdata[7:0] on the cycle after the read and clears them. An event in the read cycle is not in the returned value but is held for the next read.
- R10: irq is high exactly when status is nonzero and control bit 8 is clear.
- R11: A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| evt_seq | input | 1 | Packet-sequence event from the engine |
| evt_unexp | input | 1 | Unexpected interrupt event |
| evt_buserr | input | 1 | Host bus error event |
| eng_done | input | 1 | Engine finished the packet |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_reset | output | 1 | Engine reset, high while in HALT |
| irq | output | 1 | Maskable channel interrupt |
| pio_mode | output | 2 | PIO timing mode |
| pkt_count | output | 16 | Packet count |
| next_ptr | output | 32 | Next-packet pointer |
| fifo_in_thr | output | 16 | Input FIFO threshold |
| fifo_out_thr | output | 16 | Output FIFO threshold |

## Verification
Start requests are tried with the gate closed, with the gate opened and closed again by a wrong key, in IDLE, in RUN, in HALT, and combined with the reset bit. This separates a gate check from a state check. Each event input is raised alone, then with the mask set, and then in the same cycle as a status read. The last case shows whether a read-clear loses a new event or returns it early. Done pulses given both in RUN and in IDLE show that completion is tied to the state.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HALT = 2'd2
    } ch_state_e;

    // register byte offsets
    localparam int OFS_CTL  = 'h00;
    localparam int OFS_STAT = 'h02;
    localparam int OFS_CNT  = 'h04;
    localparam int OFS_PTR  = 'h0C;
    localparam int OFS_THI  = 'h14;
    localparam int OFS_THO  = 'h16;
    localparam int OFS_KEY  = 'h1E;

    // control word bit positions
    localparam int CB_MASK = 8;
    localparam int CB_GO   = 7;
    localparam int CB_RST  = 5;

    // status bit positions
    localparam int SB_BUSERR = 0;
    localparam int SB_DONE   = 2;
    localparam int SB_UNEXP  = 4;
    localparam int SB_SEQ    = 6;
    localparam int STAT_W    = 8;
endpackage

// File: rtl/dcc_status.sv
module dcc_status
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_seq,
    input  logic              ev_unexp,
    input  logic              ev_buserr,
    input  logic              ev_done,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        set_v            = '0;
        set_v[SB_SEQ]    = ev_seq;
        set_v[SB_UNEXP]  = ev_unexp;
        set_v[SB_BUSERR] = ev_buserr;
        set_v[SB_DONE]   = ev_done;
        // a read clears old flags; events landing now survive it
        stat_d = (rd_clr ? '0 : stat_q) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
    import dcc_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PTR_W    = 32,
    parameter int CNT_W    = 16,
    parameter int THR_W    = 16,
    parameter int KEY_W    = 8,
    parameter int KEY_OPEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [STAT_W-1:0] stat_q,
    output logic              ctl_wr,
    output logic              wr_go,
    output logic              wr_rst,
    output logic              mask_q,
    output logic              rst_q,
    output logic [1:0]        pio_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [THR_W-1:0]  thi_q,
    output logic [THR_W-1:0]  tho_q,
    output logic              gate_open,
    output logic              stat_rd,
    output logic [DATA_W-1:0] rd_mux
);
    localparam int PTR_WORDS = PTR_W / DATA_W;

    logic [KEY_W-1:0] key_q;

    logic hit_ctl, hit_stat, hit_cnt, hit_thi, hit_tho, hit_key;
    assign hit_ctl  = bus_addr == ADDR_W'(OFS_CTL);
    assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
    assign hit_cnt  = bus_addr == ADDR_W'(OFS_CNT);
    assign hit_thi  = bus_addr == ADDR_W'(OFS_THI);
    assign hit_tho  = bus_addr == ADDR_W'(OFS_THO);
    assign hit_key  = bus_addr == ADDR_W'(OFS_KEY);

    assign ctl_wr    = bus_wr && hit_ctl;
    assign wr_go     = bus_wdata[CB_GO];
    assign wr_rst    = bus_wdata[CB_RST];
    assign stat_rd   = bus_rd && hit_stat;
    assign gate_open = key_q == KEY_W'(KEY_OPEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            rst_q  <= 1'b0;
            pio_q  <= 2'd0;
            cnt_q  <= '0;
            thi_q  <= '0;
            tho_q  <= '0;
            key_q  <= '0;
        end else if (bus_wr) begin
            if (hit_ctl) begin
                mask_q <= bus_wdata[CB_MASK];
                rst_q  <= bus_wdata[CB_RST];
                pio_q  <= bus_wdata[1:0];
            end
            if (hit_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
            if (hit_thi) thi_q <= bus_wdata[THR_W-1:0];
            if (hit_tho) tho_q <= bus_wdata[THR_W-1:0];
            if (hit_key) key_q <= bus_wdata[KEY_W-1:0];
        end
    end

    // pointer is split into bus-width words at consecutive even offsets
    for (genvar w = 0; w < PTR_WORDS; w++) begin : g_ptr
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(OFS_PTR + 2 * w))
                word_q <= bus_wdata;
        end
        assign ptr_q[w*DATA_W +: DATA_W] = word_q;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctl) begin
            rd_mux[CB_MASK] = mask_q;
            rd_mux[CB_RST]  = rst_q;
            rd_mux[1:0]     = pio_q;
        end
        if (hit_stat) rd_mux[STAT_W-1:0] = stat_q;
        if (hit_cnt)  rd_mux[CNT_W-1:0]  = cnt_q;
        if (hit_thi)  rd_mux[THR_W-1:0]  = thi_q;
        if (hit_tho)  rd_mux[THR_W-1:0]  = tho_q;
        if (hit_key)  rd_mux[KEY_W-1:0]  = key_q;
        for (int w = 0; w < PTR_WORDS; w++) begin
            if (bus_addr == ADDR_W'(OFS_PTR + 2 * w))
                rd_mux = ptr_q[w*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
    import dcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic      wr_go,
    input  logic      wr_rst,
    input  logic      rst_q,
    input  logic      gate_open,
    input  logic      eng_done,
    output logic      done_ok,
    output logic      eng_start,
    output logic      eng_reset,
    output ch_state_e state_q
);
    ch_state_e state_d;
    logic      go_ok;

    assign go_ok   = ctl_wr && wr_go && !wr_rst && !rst_q && gate_open
                     && state_q == CH_IDLE;
    assign done_ok = state_q == CH_RUN && eng_done && !rst_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (rst_q)      state_d = CH_HALT;  // HOLD
                else if (go_ok) state_d = CH_RUN;   // GO
            end
            CH_RUN: begin
                if (rst_q)         state_d = CH_HALT;  // HOLD
                else if (eng_done) state_d = CH_IDLE;  // FINISH
            end
            CH_HALT: begin
                if (!rst_q) state_d = CH_IDLE;      // RELEASE
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_reset <= 1'b0;
        end else begin
            eng_start <= go_ok;
            eng_reset <= state_d == CH_HALT;
        end
    end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dcc_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PTR_W    = 32,
    parameter int CNT_W    = 16,
    parameter int THR_W    = 16,
    parameter int KEY_W    = 8,
    parameter int KEY_OPEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_seq,
    input  logic              evt_unexp,
    input  logic              evt_buserr,
    input  logic              eng_done,
    output logic              eng_start,
    output logic              eng_reset,
    output logic              irq,
    output logic [1:0]        pio_mode,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [THR_W-1:0]  fifo_in_thr,
    output logic [THR_W-1:0]  fifo_out_thr
);
    logic              ctl_wr, wr_go, wr_rst;
    logic              ctl_mask, rst_q, gate_open, stat_rd, done_ok;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] rd_mux;
    ch_state_e         ch_state;

    dcc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W),
        .THR_W(THR_W), .KEY_W(KEY_W), .KEY_OPEN(KEY_OPEN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_q(stat_q),
        .ctl_wr(ctl_wr), .wr_go(wr_go), .wr_rst(wr_rst),
        .mask_q(ctl_mask), .rst_q(rst_q), .pio_q(pio_mode),
        .cnt_q(pkt_count), .ptr_q(next_ptr), .thi_q(fifo_in_thr),
        .tho_q(fifo_out_thr), .gate_open(gate_open), .stat_rd(stat_rd),
        .rd_mux(rd_mux)
    );

    dcc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_go(wr_go),
        .wr_rst(wr_rst), .rst_q(rst_q), .gate_open(gate_open),
        .eng_done(eng_done), .done_ok(done_ok), .eng_start(eng_start),
        .eng_reset(eng_reset), .state_q(ch_state)
    );

    dcc_status u_stat (
        .clk(clk), .rst_n(rst_n), .ev_seq(evt_seq), .ev_unexp(evt_unexp),
        .ev_buserr(evt_buserr), .ev_done(done_ok), .rd_clr(stat_rd),
        .stat_q(stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = (|stat_q) && !ctl_mask;
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk
    import dcc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              evt_seq,
    input logic              evt_unexp,
    input logic              evt_buserr,
    input logic              eng_done,
    input logic              eng_start,
    input logic              eng_reset,
    input logic              irq,
    input logic              ctl_mask,
    input logic              gate_open,
    input logic [STAT_W-1:0] stat_q
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(gate_open));

    // R5
    start_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !eng_start);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mask |-> !irq);

    // R8
    buserr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buserr |=> stat_q[SB_BUSERR]);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_STAT) && !evt_seq && !evt_unexp
         && !evt_buserr && !eng_done) |=> stat_q == '0);
endmodule

bind dma_chan_ctl dcc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .evt_seq(evt_seq), .evt_unexp(evt_unexp), .evt_buserr(evt_buserr),
    .eng_done(eng_done), .eng_start(eng_start), .eng_reset(eng_reset),
    .irq(irq), .ctl_mask(ctl_mask), .gate_open(gate_open), .stat_q(stat_q)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        evt_seq = 1'b0, evt_unexp = 1'b0, evt_buserr = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_start, eng_reset, irq;
    logic [1:0]  pio_mode;
    logic [15:0] pkt_count, fifo_in_thr, fifo_out_thr;
    logic [31:0] next_ptr;

    int total = 0, fails = 0, starts = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        rd_done;

    always #4 clk = ~clk;

    dma_chan_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_seq(evt_seq), .evt_unexp(evt_unexp), .evt_buserr(evt_buserr),
        .eng_done(eng_done), .eng_start(eng_start), .eng_reset(eng_reset),
        .irq(irq), .pio_mode(pio_mode), .pkt_count(pkt_count),
        .next_ptr(next_ptr), .fifo_in_thr(fifo_in_thr),
        .fifo_out_thr(fifo_out_thr)
    );

    always @(posedge clk) if (eng_start) starts++;

    // monitor: compare each read result with the queued expectation
    always @(rd_done) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        ->rd_done;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(posedge clk); #1; eng_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int s0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 eng_start", eng_start, 0);
        chk("R1 eng_reset", eng_reset, 0);
        rd(5'h00, 16'h0100, "R1 control");
        rd(5'h02, 16'h0000, "R1 status");
        rd(5'h1E, 16'h0000, "R1 key");

        // R2 configuration
        wr(5'h04, 16'h0001);
        wr(5'h0C, 16'hBEE8);
        wr(5'h0E, 16'h1234);
        wr(5'h14, 16'h0100);
        wr(5'h16, 16'h0080);
        wr(5'h00, 16'h0103);
        rd(5'h04, 16'h0001, "R2 count");
        rd(5'h0C, 16'hBEE8, "R2 ptr low");
        rd(5'h0E, 16'h1234, "R2 ptr high");
        rd(5'h14, 16'h0100, "R2 in thr");
        rd(5'h16, 16'h0080, "R2 out thr");
        chk("R2 next_ptr", next_ptr, 32'h1234BEE8);
        chk("R2 pio_mode", pio_mode, 3);
        chk("R2 outputs", {pkt_count, fifo_in_thr}, {16'h0001, 16'h0100});
        rd(5'h00, 16'h0103, "R2 control");

        // R5 start with gate closed
        s0 = starts;
        wr(5'h00, 16'h0183);
        idle(3);
        chk("R5 start while locked", starts - s0, 0);
        rd(5'h00, 16'h0103, "R4 go reads zero");

        // R3 key open and close
        wr(5'h1E, 16'h0007);
        rd(5'h1E, 16'h0007, "R3 key readback");
        wr(5'h1E, 16'h0005);
        s0 = starts;
        wr(5'h00, 16'h0083);
        idle(3);
        chk("R3 wrong key blocks start", starts - s0, 0);
        wr(5'h1E, 16'h0007);

        // R4 accepted start
        s0 = starts;
        wr(5'h00, 16'h0083);
        chk("R4 pulse after write", eng_start, 1);
        idle(1);
        chk("R4 pulse one cycle", eng_start, 0);
        idle(2);
        chk("R4 single pulse", starts - s0, 1);
        rd(5'h00, 16'h0003, "R4 control readback");

        // R5 start while running
        s0 = starts;
        wr(5'h00, 16'h0083);
        idle(3);
        chk("R5 start while running", starts - s0, 0);

        // R7 completion
        pulse_done();
        idle(1);
        chk("R10 irq on done", irq, 1);
        rd(5'h02, 16'h0004, "R7 done flag");
        idle(1);
        chk("R9 irq cleared by read", irq, 0);
        s0 = starts;
        wr(5'h00, 16'h0083);
        idle(2);
        chk("R7 back to idle accepts start", starts - s0, 1);
        pulse_done();
        rd(5'h02, 16'h0004, "R7 second done");
        pulse_done();
        idle(1);
        rd(5'h02, 16'h0000, "R7 done in idle ignored");

        // R8 event flags
        @(negedge clk); evt_seq = 1'b1;
        @(negedge clk); evt_seq = 1'b0; evt_unexp = 1'b1;
        @(negedge clk); evt_unexp = 1'b0; evt_buserr = 1'b1;
        @(negedge clk); evt_buserr = 1'b0;
        idle(2);
        rd(5'h02, 16'h0051, "R8 sticky flags");

        // R10 masked interrupt
        wr(5'h00, 16'h0103);
        @(negedge clk); evt_buserr = 1'b1;
        @(negedge clk); evt_buserr = 1'b0;
        idle(1);
        chk("R10 masked irq", irq, 0);
        wr(5'h00, 16'h0003);
        chk("R10 unmasked irq", irq, 1);

        // R9 event in the read cycle is kept
        @(negedge clk);
        bus_addr = 5'h02; bus_rd = 1'b1; evt_seq = 1'b1;
        exp_q.push_back(16'h0001); tag_q.push_back("R9 read returns old");
        @(posedge clk); #1;
        bus_rd = 1'b0; evt_seq = 1'b0;
        ->rd_done;
        #1;
        rd(5'h02, 16'h0040, "R9 coincident event kept");

        // R6 reset hold and release
        wr(5'h00, 16'h0023);
        idle(2);
        chk("R6 eng_reset high", eng_reset, 1);
        s0 = starts;
        wr(5'h00, 16'h00A3);
        idle(2);
        chk("R5 start with reset bit", starts - s0, 0);
        wr(5'h00, 16'h0083);
        idle(2);
        chk("R5 start during halt", starts - s0, 0);
        chk("R6 eng_reset released", eng_reset, 0);
        wr(5'h00, 16'h0083);
        idle(2);
        chk("R6 start after release", starts - s0, 1);
        wr(5'h00, 16'h0023);
        idle(2);
        chk("R6 reset from run", eng_reset, 1);
        wr(5'h00, 16'h0003);
        idle(2);
        chk("R6 released from run", eng_reset, 0);

        // R11 unmapped read
        rd(5'h08, 16'h0000, "R11 unmapped");

        idle(2);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule